// File: doc/BRIEF.md
# Repeating Transmit FIFO Controller

This block sits between a host and a byte serializer on a signaling link. The host loads a message into a transmit FIFO one byte at a time and then issues a command. A plain send command transmits the FIFO contents once and frees them. A repeat command keeps transmitting the same contents back to back. Repetition replays the stored bytes from a saved start pointer and frees nothing until it has ended.

Clearing the repeat bit never cuts a message short. The pass in progress completes and the stored bytes are then released. Two kinds of fill-in frame cover the idle time. When the continuous fill-in mode is on, short fill-in frames follow a cleared repetition automatically. When that mode is off, the host can request a single fill-in frame. A fill-in frame is a fixed pattern held in a parameter and does not use the FIFO. Flag insertion, CRC and bit stuffing belong to the downstream serializer.

Top module: `rep_tx_fifo`

## Requirements
- R1: A byte offered on `wr_en`/`wr_data` is stored when the FIFO holds fewer than DEPTH bytes. A byte offered when the FIFO is full is dropped. Stored bytes are transmitted in the order they were written.
- R2: A command write with `cmd_xmit`=1 and `cmd_rep`=0 sends every byte stored at the command edge exactly once. Those bytes are then freed and the block returns to idle.
- R3: A command write with `cmd_rep`=1 sends the stored bytes repeatedly. The first byte of a pass is offered in the cycle that follows acceptance of the last byte of the previous pass, so there is no gap between passes.
- R4: A command write with `cmd_rep`=1 during a repetition neither restarts nor interrupts the pass in progress.
- R5: A command write with `cmd_rep`=0 during a repetition lets the current pass finish, then ends the repetition and frees the message bytes.
- R6: `rep_active` is low after reset. It is high from the cycle after a repeat command starts a message until the edge that accepts the final byte of the last pass, and `out_valid` is high whenever it is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: A fill-in frame is the three bytes of FILL_PATTERN, most significant byte first.
- R9: If `fill_cont`=1 when a repetition ends, fill-in frames follow it back to back. They stop at a frame boundary once `fill_cont` is 0.
- R10: A command write with `cmd_fill`=1 while `fill_cont`=0 sends exactly one fill-in frame. While `fill_cont`=1, `cmd_fill` has no effect.
- R11: A send or repeat command is acted on only when the block is idle and the FIFO is not empty. Otherwise it starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | FIFO byte write strobe |
| wr_data | input | W | Byte to store |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_xmit | input | 1 | Command: send FIFO contents once |
| cmd_rep | input | 1 | Command: repeat bit (set or clear) |
| cmd_fill | input | 1 | Command: one-shot fill-in frame request |
| fill_cont | input | 1 | Fill-in mode: 0 none/one-shot, 1 continuous |
| rep_active | output | 1 | Repetitive transmission in progress |
| out_valid | output | 1 | Byte offered to the serializer |
| out_ready | input | 1 | Serializer accepts the byte |
| out_data | output | W | Byte offered |

## Verification
The hardest case to reach is a clear of the repeat bit that lands at an exact, known position inside a pass. If the clear coincides with the edge that accepts the last byte of a pass, the length of the tail is ambiguous. To avoid that, the bench first waits a random number of bytes into the repetition. It then drops `out_ready` so that nothing is accepted at the command edge and issues the clear. From the number of bytes already captured it computes how long the tail must be. Randomized message lengths, including a single byte, and random ready patterns then show that the tail completes the pass without a gap. In the runs with continuous fill-in enabled, the bench also checks that fill-in frames follow the tail and stop only on a frame boundary.

// File: rtl/rep_tx_fifo.sv
module rep_tx_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  parameter int FILL_LEN = 3,
  parameter logic [FILL_LEN*W-1:0] FILL_PATTERN = 24'hA5_3C_0F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         cmd_wr,
  input  logic         cmd_xmit,
  input  logic         cmd_rep,
  input  logic         cmd_fill,
  input  logic         fill_cont,
  output logic         rep_active,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int FW = $clog2(FILL_LEN);

  typedef enum logic [1:0] {S_IDLE, S_MSG, S_FILL} state_t;

  state_t        state;
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, msg_base;
  logic [CW-1:0] cnt, msg_len, idx;
  logic [FW-1:0] fill_idx;
  logic          rep_flag, rep_run, fill_once, fill_pend;

  wire fire      = out_valid && out_ready;
  wire wr_ok     = wr_en && (cnt < CW'(DEPTH));
  wire last      = (idx == msg_len - 1'b1);
  wire again     = rep_run && rep_flag;
  wire done_free = (state == S_MSG) && fire && last && !again;
  wire start     = cmd_wr && (cmd_xmit || cmd_rep) && (cnt != '0);

  assign out_valid  = (state != S_IDLE);
  assign rep_active = (state == S_MSG) && rep_run;
  assign out_data   = (state == S_FILL)
                    ? FILL_PATTERN[W*(FILL_LEN-1-int'(fill_idx)) +: W]
                    : mem[rd_ptr];

  always_ff @(posedge clk) if (wr_ok) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      cnt <= cnt + CW'(wr_ok) - (done_free ? msg_len : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rd_ptr    <= '0;
      msg_base  <= '0;
      msg_len   <= '0;
      idx       <= '0;
      fill_idx  <= '0;
      rep_flag  <= 1'b0;
      rep_run   <= 1'b0;
      fill_once <= 1'b0;
      fill_pend <= 1'b0;
    end else begin
      if (cmd_wr) rep_flag <= cmd_rep;
      if (cmd_wr && cmd_fill && !fill_cont) fill_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_MSG;
            msg_base <= rd_ptr;
            msg_len  <= cnt;
            idx      <= '0;
            rep_run  <= cmd_rep;
          end else if (fill_pend) begin
            state     <= S_FILL;
            fill_idx  <= '0;
            fill_once <= 1'b1;
            fill_pend <= 1'b0;
          end
        end
        S_MSG: begin
          if (fire) begin
            if (!last) begin
              rd_ptr <= rd_ptr + 1'b1;
              idx    <= idx + 1'b1;
            end else if (again) begin
              rd_ptr <= msg_base;
              idx    <= '0;
            end else begin
              rd_ptr  <= rd_ptr + 1'b1;
              rep_run <= 1'b0;
              if (rep_run && fill_cont) begin
                state     <= S_FILL;
                fill_idx  <= '0;
                fill_once <= 1'b0;
              end else begin
                state <= S_IDLE;
              end
            end
          end
        end
        S_FILL: begin
          if (fire) begin
            if (fill_idx == FW'(FILL_LEN - 1)) begin
              fill_idx <= '0;
              if (fill_once || !fill_cont) state <= S_IDLE;
            end else begin
              fill_idx <= fill_idx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
  AST_REP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rep_active |-> out_valid); // R6
  AST_REP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rep_active && cmd_wr && cmd_rep |=> rep_active); // R4
  AST_FIFO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rep_active && rep_flag |=> cnt >= $past(cnt)); // R5
  AST_FILL_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FILL && !fill_once |=> !rep_active); // R9
endmodule

// File: tb/rep_tx_fifo_tb.sv
`timescale 1ns/1ps
module rep_tx_fifo_tb;
  localparam int W = 8;
  localparam int DEPTH = 16;
  localparam logic [23:0] PAT = 24'hA5_3C_0F;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, cmd_wr = 0, cmd_xmit = 0, cmd_rep = 0, cmd_fill = 0, fill_cont = 0;
  logic [W-1:0] wr_data = '0;
  logic out_ready = 0;
  logic rep_active, out_valid;
  logic [W-1:0] out_data;

  int nchk = 0, nerr = 0, ncap = 0, ready_mode = 0;
  logic [W-1:0] cap [0:8191];
  logic [W-1:0] msg [0:31];
  logic hold_pend = 0;
  logic [W-1:0] hold_data = '0;

  rep_tx_fifo #(.W(W), .DEPTH(DEPTH), .FILL_LEN(3), .FILL_PATTERN(PAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_wr(cmd_wr), .cmd_xmit(cmd_xmit), .cmd_rep(cmd_rep), .cmd_fill(cmd_fill),
    .fill_cont(fill_cont), .rep_active(rep_active), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: out_ready = 0;
      1: out_ready = 1;
      default: out_ready = ($urandom_range(0, 3) != 0);
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    if (hold_pend) begin
      nchk++;
      if (!(out_valid && out_data == hold_data)) begin
        nerr++;
        $display("FAIL R7 hold: valid=%0b data=%02h expected valid=1 data=%02h", out_valid, out_data, hold_data);
      end
    end
    hold_pend = out_valid && !out_ready;
    hold_data = out_data;
    if (out_valid && out_ready) begin
      cap[ncap] = out_data;
      ncap++;
    end
  end

  function automatic logic [W-1:0] fill_byte(int i);
    return PAT[8*(2 - (i % 3)) +: 8];
  endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic [W-1:0] b);
    @(posedge clk); #2 wr_en = 1; wr_data = b;
    @(posedge clk); #2 wr_en = 0;
  endtask

  task automatic cmd(logic x, logic r, logic f);
    @(posedge clk); #2 cmd_wr = 1; cmd_xmit = x; cmd_rep = r; cmd_fill = f;
    @(posedge clk); #2 cmd_wr = 0; cmd_xmit = 0; cmd_rep = 0; cmd_fill = 0;
  endtask

  task automatic wait_cap(int n);
    for (int i = 0; i < 3000 && ncap < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic load(int len);
    for (int i = 0; i < len; i++) begin
      msg[i] = W'($urandom);
      wr_byte(msg[i]);
    end
  endtask

  task automatic check_msg(string req, int base, int len, int total);
    int bad = 0, fi = -1;
    for (int i = 0; i < total; i++)
      if (cap[base+i] !== msg[i % len]) begin
        bad++;
        if (fi < 0) fi = i;
      end
    nchk++;
    if (bad != 0) begin
      nerr++;
      $display("FAIL %s byte %0d actual=%02h expected=%02h", req, fi, cap[base+fi], msg[fi % len]);
    end
  endtask

  task automatic rep_test(int len, int extra, bit use_fill);
    int base, c, total, fn, bad, a;
    base = ncap;
    load(len);
    ready_mode = 1;
    cmd(0, 1, 0);
    check("R6 rep_active after start", int'(rep_active), 1);
    a = ncap;
    idle(2*len + 1);
    check("R3 no gap between passes", ncap - a, 2*len + 1);
    ready_mode = 2;
    cmd(0, 1, 0);
    check("R4 still repeating after rewrite", int'(rep_active), 1);
    wait_cap(base + 3*len + extra);
    fill_cont = use_fill;
    ready_mode = 0;
    cmd(0, 0, 0);
    c = ncap - base;
    total = (c / len + 1) * len;
    ready_mode = 2;
    wait_cap(base + total);
    if (!use_fill) begin
      idle(30);
      check("R5 pass completes then stops", ncap - base, total);
      check("R6 rep_active low after end", int'(rep_active), 0);
      check_msg("R3 repeated contents", base, len, total);
    end else begin
      wait_cap(base + total + 7);
      fill_cont = 0;
      idle(40);
      check_msg("R3 repeated contents", base, len, total);
      fn = ncap - base - total;
      check("R9 fill frames whole", fn % 3, 0);
      check("R9 fill frames follow", int'(fn >= 9), 1);
      bad = 0;
      for (int i = 0; i < fn; i++) if (cap[base+total+i] !== fill_byte(i)) bad++;
      check("R8 fill pattern bytes", bad, 0);
    end
    c = ncap;
    cmd(1, 0, 0);
    idle(20);
    check("R11 empty FIFO after repeat", ncap - c, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int base, c, bad;
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1;
    #1;
    check("R6 reset rep_active", int'(rep_active), 0);
    check("R2 reset out_valid", int'(out_valid), 0);

    base = ncap;
    load(5);
    ready_mode = 2;
    cmd(1, 0, 0);
    wait_cap(base + 5);
    idle(20);
    check("R2 single send count", ncap - base, 5);
    check_msg("R2 single send order", base, 5, 5);
    c = ncap;
    cmd(1, 0, 0);
    idle(20);
    check("R11 start with empty FIFO", ncap - c, 0);

    base = ncap;
    load(DEPTH + 3);
    cmd(1, 0, 0);
    wait_cap(base + DEPTH);
    idle(20);
    check("R1 full FIFO drops writes", ncap - base, DEPTH);
    check_msg("R1 stored order", base, DEPTH + 3, DEPTH);

    base = ncap;
    load(4);
    ready_mode = 0;
    cmd(1, 0, 0);
    idle(5);
    cmd(1, 0, 0);
    ready_mode = 2;
    wait_cap(base + 4);
    idle(20);
    check("R11 busy command ignored", ncap - base, 4);

    rep_test(1, 0, 0);
    rep_test(DEPTH, 5, 0);
    for (int k = 0; k < 6; k++)
      rep_test($urandom_range(2, 9), $urandom_range(0, 9), k[0]);

    base = ncap;
    fill_cont = 0;
    ready_mode = 2;
    cmd(0, 0, 1);
    idle(30);
    check("R10 one-shot fill count", ncap - base, 3);
    bad = 0;
    for (int i = 0; i < 3; i++) if (cap[base+i] !== fill_byte(i)) bad++;
    check("R8 one-shot fill bytes", bad, 0);
    fill_cont = 1;
    c = ncap;
    cmd(0, 0, 1);
    idle(30);
    check("R10 fill request ignored in continuous mode", ncap - c, 0);
    fill_cont = 0;

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule